// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block counts video scanlines and raises an interrupt after a programmed number of them. An external pulse arrives once per scanline. Each pulse either reloads an 8-bit down-counter from a software-written latch or decrements it by one. The interrupt line goes high when a nonzero count steps down to zero while interrupts are enabled. It then stays high until software acknowledges it.

Software reaches the block through plain register writes. Address bits 15..13 and bit 0 pick the register. The pair at 0xC000/0xC001 sets the latch value and requests a reload. The pair at 0xE000/0xE001 disables and acknowledges the interrupt, or enables it. Bank-select writes elsewhere in the cartridge space leave the block alone. An 8-bit mapper-mode input has one value that selects a fixed-bank configuration. While that value is present, the block ignores both scanline pulses and register writes, so all of its state is frozen.

Top module: `scanline_irq_counter`

## Requirements
- R1: Reset clears the counter, the latch, the enable flag, the reload request and the interrupt output. After reset, enabling interrupts and sending pulses never raises the interrupt until a nonzero latch value has been written.
- R2: A write whose address has bits 15..13 equal to 3'b110 and bit 0 equal to 0 (for example 0xC000) stores the data byte in the latch.
- R3: A write with bits 15..13 equal to 3'b110 and bit 0 equal to 1 (for example 0xC001) sets a reload request. It leaves the counter unchanged until the next scanline pulse.
- R4: On a scanline pulse, if the counter is zero or a reload is requested, the counter takes the latch value and the request clears. Otherwise the counter decrements by one.
- R5: The interrupt output rises after the pulse on which the count goes from nonzero to zero while interrupts are enabled. With latch N (N at least 1) written and a reload requested, it rises on pulse N+1.
- R6: A pulse that moves the counter from zero to zero (a reload of latch value 0 while the count is already zero) never raises the interrupt.
- R7: A write with bits 15..13 equal to 3'b111 and bit 0 equal to 0 (0xE000) clears the enable flag and drops the interrupt output. The same bits with bit 0 equal to 1 (0xE001) set the enable flag.
- R8: Once high, the interrupt output stays high through later pulses until a 0xE000 write.
- R9: While the mode input equals the frozen value (default 0x13), scanline pulses and register writes have no effect on the counter, latch, enable, reload request or interrupt output.
- R10: Writes at 0x8000, 0x8001, 0xA000 and 0xA001 have no effect on the block.
- R11: With interrupts disabled, the counter reaching zero does not raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 16 | Write address |
| wrData | input | 8 | Write data |
| lineTick | input | 1 | One-cycle pulse per scanline |
| modeSel | input | 8 | Mapper mode; the frozen value stops the block |
| irq | output | 1 | Active-high interrupt, held until acknowledged |

## Verification
The main sweep covers every latch value from 1 to 255. Each one is loaded through a reload request with interrupts enabled, and the interrupt output is compared after every pulse. This catches an off-by-one in the reload or decrement path and any missed or early firing at any count. Latch value 0 is tried from both a zero count and a nonzero count, which separates a reload that lands on zero from a real decrement to zero. Frozen-mode stretches, writes to the bank-select addresses, and pulses while interrupts are disabled are placed in the middle of a count. Any state they disturbed would then show up as a shifted interrupt time.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

  typedef struct packed {
    logic latchWr;
    logic reloadReq;
    logic irqOff;
    logic irqOn;
    logic tick;
  } irqStrobes_t;

endpackage

// File: rtl/scanirq_ctrl.sv
module scanirq_ctrl
  import scanirq_pkg::*;
#(
  parameter int MODE_W = 8,
  parameter logic [MODE_W-1:0] FROZEN_MODE = 8'h13
) (
  input  logic              wrEn,
  input  logic [2:0]        regBank,
  input  logic              regOdd,
  input  logic              lineTick,
  input  logic [MODE_W-1:0] modeSel,
  output irqStrobes_t       strobes
);

  localparam logic [2:0] BANK_COUNT = 3'b110;
  localparam logic [2:0] BANK_ENABLE = 3'b111;

  logic frozen;
  logic wrLive;

  assign frozen = (modeSel == FROZEN_MODE);
  assign wrLive = wrEn && !frozen;

  always_comb begin
    strobes.latchWr   = wrLive && (regBank == BANK_COUNT) && !regOdd;
    strobes.reloadReq = wrLive && (regBank == BANK_COUNT) && regOdd;
    strobes.irqOff    = wrLive && (regBank == BANK_ENABLE) && !regOdd;
    strobes.irqOn     = wrLive && (regBank == BANK_ENABLE) && regOdd;
    strobes.tick      = lineTick && !frozen;
  end

endmodule

// File: rtl/scanirq_datapath.sv
module scanirq_datapath
  import scanirq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] wrData,
  input  irqStrobes_t      strobes,
  output logic [CNT_W-1:0] cntVal,
  output logic             irq
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] latchQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic             pendQ;
  logic             enQ;
  logic             irqQ;
  logic             fire;

  always_comb begin
    cntNext = cntQ;
    if (strobes.tick) begin
      if ((cntQ == CNT_ZERO) || pendQ) cntNext = latchQ;
      else                             cntNext = cntQ - 1'b1;
    end
  end

  assign fire = strobes.tick && (cntQ != CNT_ZERO) && (cntNext == CNT_ZERO) && enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      cntQ   <= '0;
      pendQ  <= 1'b0;
      enQ    <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      cntQ <= cntNext;
      if (strobes.latchWr) latchQ <= wrData;
      if (strobes.reloadReq)  pendQ <= 1'b1;
      else if (strobes.tick)  pendQ <= 1'b0;
      if (strobes.irqOff)     enQ <= 1'b0;
      else if (strobes.irqOn) enQ <= 1'b1;
      if (strobes.irqOff)     irqQ <= 1'b0;
      else if (fire)          irqQ <= 1'b1;
    end
  end

  assign cntVal = cntQ;
  assign irq    = irqQ;

  AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> (cntQ == CNT_ZERO)); // R5

  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(enQ)); // R11

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && !strobes.irqOff) |=> irqQ); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.irqOff |=> (!irqQ && !enQ)); // R7

  AST_RELOAD_DEFERRED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.reloadReq && !strobes.tick) |=> $stable(cntQ)); // R3

endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import scanirq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int MODE_W = 8,
  parameter logic [MODE_W-1:0] FROZEN_MODE = 8'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [15:0]       wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              lineTick,
  input  logic [MODE_W-1:0] modeSel,
  output logic              irq
);

  irqStrobes_t      strobes;
  logic [CNT_W-1:0] cntVal;
  logic             unusedAddr;

  assign unusedAddr = ^wrAddr[12:1];

  scanirq_ctrl #(
    .MODE_W(MODE_W),
    .FROZEN_MODE(FROZEN_MODE)
  ) ctrl_i (
    .wrEn(wrEn),
    .regBank(wrAddr[15:13]),
    .regOdd(wrAddr[0]),
    .lineTick(lineTick),
    .modeSel(modeSel),
    .strobes(strobes)
  );

  scanirq_datapath #(
    .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .wrData(wrData),
    .strobes(strobes),
    .cntVal(cntVal),
    .irq(irq)
  );

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == FROZEN_MODE) |=> ($stable(cntVal) && $stable(irq))); // R9

endmodule

// File: tb/scanline_irq_counter_tb_top.sv
module scanline_irq_counter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        lineTick = 1'b0;
  logic [7:0]  modeSel = '0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int mCnt, mLatch;
  bit mPend, mEn, mIrq;

  always #4 clk = ~clk;

  scanline_irq_counter dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lineTick(lineTick), .modeSel(modeSel), .irq(irq)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mCnt = 0; mLatch = 0; mPend = 0; mEn = 0; mIrq = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (modeSel != 8'h13) begin
      case ({a[15:13], a[0]})
        4'b1100: mLatch = d;
        4'b1101: mPend = 1;
        4'b1110: begin mEn = 0; mIrq = 0; end
        4'b1111: mEn = 1;
        default: ;
      endcase
    end
  endtask

  task automatic tick(input string tag);
    int old;
    @(negedge clk);
    lineTick = 1'b1;
    @(negedge clk);
    lineTick = 1'b0;
    if (modeSel != 8'h13) begin
      old = mCnt;
      if (mCnt == 0 || mPend) begin mCnt = mLatch; mPend = 0; end
      else mCnt = mCnt - 1;
      if (old != 0 && mCnt == 0 && mEn) mIrq = 1;
    end
    check(tag, irq, mIrq);
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    check("R1", irq, 1'b0);

    // R1 / R6: latch cleared by reset, counter zero reloads zero, never fires
    wr(16'hE001, 8'h00);
    for (int i = 0; i < 4; i++) tick("R6");
    wr(16'hC001, 8'h00);
    for (int i = 0; i < 3; i++) tick("R1");

    // R4 / R5 sweep every nonzero latch value
    for (int n = 1; n < 256; n++) begin
      wr(16'hE000, 8'h00);
      wr(16'hC000, 8'(n));
      wr(16'hC001, 8'h00);
      wr(16'hE001, 8'h00);
      for (int k = 0; k <= n; k++) tick((k == n) ? "R5" : "R4");
      check("R5", irq, 1'b1);
      tick("R8");
      tick("R8");
      check("R8", irq, 1'b1);
    end

    // R7 acknowledge
    wr(16'hE000, 8'h00);
    check("R7", irq, 1'b0);

    // R11 disabled: count to zero without firing
    wr(16'hC000, 8'h03);
    wr(16'hC001, 8'h00);
    for (int i = 0; i < 6; i++) tick("R11");
    check("R11", irq, 1'b0);

    // R2 / R3: latch write alone does not reload, count keeps running
    wr(16'hE001, 8'h00);
    wr(16'hC000, 8'h05);
    wr(16'hC001, 8'h00);
    tick("R3");
    wr(16'hC000, 8'h02);
    for (int i = 0; i < 6; i++) tick("R2");
    wr(16'hE000, 8'h00);
    wr(16'hE001, 8'h00);
    wr(16'hC001, 8'h00);
    for (int i = 0; i < 4; i++) tick("R3");

    // R6 contrast: nonzero count with latch 0 reloaded fires
    wr(16'hE000, 8'h00);
    wr(16'hE001, 8'h00);
    wr(16'hC000, 8'h04);
    wr(16'hC001, 8'h00);
    tick("R4");
    tick("R4");
    wr(16'hC000, 8'h00);
    wr(16'hC001, 8'h00);
    tick("R6");
    check("R6", irq, 1'b1);

    // R10 bank-select writes ignored
    wr(16'hE000, 8'h00);
    wr(16'hE001, 8'h00);
    wr(16'hC000, 8'h03);
    wr(16'hC001, 8'h00);
    tick("R10");
    wr(16'h8000, 8'h00);
    wr(16'h8001, 8'h01);
    wr(16'hA000, 8'h00);
    wr(16'hA001, 8'h00);
    for (int i = 0; i < 4; i++) tick("R10");
    check("R10", irq, 1'b1);

    // R9 frozen mode
    wr(16'hE000, 8'h00);
    wr(16'hE001, 8'h00);
    wr(16'hC000, 8'h06);
    wr(16'hC001, 8'h00);
    tick("R9");
    tick("R9");
    @(negedge clk);
    modeSel = 8'h13;
    for (int i = 0; i < 10; i++) tick("R9");
    wr(16'hC000, 8'h01);
    wr(16'hC001, 8'h00);
    wr(16'hE000, 8'h00);
    @(negedge clk);
    modeSel = 8'h37;
    for (int i = 0; i < 7; i++) tick("R9");
    check("R9", irq, 1'b1);
    @(negedge clk);
    modeSel = 8'h13;
    wr(16'hE000, 8'h00);
    check("R9", irq, 1'b1);
    @(negedge clk);
    modeSel = 8'hFF;

    // R1 reset mid-run clears latch and irq
    doReset();
    check("R1", irq, 1'b0);
    wr(16'hE001, 8'h00);
    wr(16'hC001, 8'h00);
    for (int i = 0; i < 4; i++) tick("R1");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule